// File: doc/BRIEF.md
# Boot Block Protection Unit

This unit sits between the command decoder and the array controller of a word-wide flash macro. It maps each word address onto one of four erase sectors: a boot sector, two parameter sectors and the main array. A parameter places the boot sector either at the lowest or at the highest addresses. For every program, sector-erase or chip-erase request it decides whether the operation may touch each sector. It then drives the sector erase enables or the program permit for the length of the internal operation.

A lock command sets a sticky boot-lockout flag. The bus reset leaves that flag alone, and only the power-on initialisation input clears it. While the flag is set, a program or sector erase aimed at the boot sector is refused, and a chip erase leaves the boot sector out. A high-voltage override input lifts the lock, but only while it stays asserted. If the override is released partway through an operation that relies on it, that operation is aborted. In identification mode the unit supplies the read word: the manufacturer code, the device code, or the lock state.

Top module: `boot_guard`

## Requirements
- R1: With TOP_BOOT=0, the sector output (0 boot, 1 parameter 1, 2 parameter 2, 3 main) is 0 for words 0x00000..0x01FFF, 1 for 0x02000..0x02FFF, 2 for 0x03000..0x03FFF and 3 for 0x04000..0x3FFFF.
- R2: With TOP_BOOT=1, the sector output is 0 for 0x3E000..0x3FFFF, 1 for 0x3D000..0x3DFFF, 2 for 0x3C000..0x3CFFF and 3 for 0x00000..0x3BFFF.
- R3: A lock command pulse sets the lockout flag at the next clock edge. Asserting rst_ni does not clear the flag; only por_ni does.
- R4: While the flag is set and the override is low, a program or sector erase that addresses the boot sector is refused. It gives a one-cycle reject pulse, no busy period, no erase enable and no program permit.
- R5: Erase enables use bit 0 for boot, bit 1 for parameter 1, bit 2 for parameter 2 and bit 3 for main. A chip erase drives 4'b1111 when unlocked and 4'b1110 when locked without the override. A sector erase drives the one bit of the addressed sector.
- R6: With the override high at the request, a boot-sector operation is accepted despite the lock. If the override falls while such an operation runs, the operation ends at the next edge with a one-cycle reject pulse. Once the override is low, the lock applies again.
- R7: An accepted operation raises busy_o, together with its erase enables or its program permit, from the clock edge that samples the request for exactly OP_CYCLES cycles.
- R8: While busy_o is high, new program, erase and lock requests are ignored.
- R9: Requests in the same cycle are ranked chip erase, then sector erase, then program; only the highest is performed.
- R10: In ID mode, with address bits above bit 0 all zero, id_data_o is 0x161F for bit 0 = 0. For bit 0 = 1 it is the device code: 0x1692 for bottom boot, 0x1690 for top boot.
- R11: In ID mode, a read at boot base + 2 returns the lock flag on bit 0 with the other bits zero. Other addresses read 0, and id_data_o is 0 outside ID mode.
- R12: A lock command and a boot-sector request in the same cycle: the request is judged against the lock state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset, leaves the lock flag |
| por_ni | input | 1 | Active-low power-on initialisation, clears the lock flag |
| addr_i | input | ADDR_W | Word address |
| prog_req_i | input | 1 | Program request pulse |
| serase_req_i | input | 1 | Sector erase request pulse |
| cerase_req_i | input | 1 | Chip erase request pulse |
| lock_req_i | input | 1 | Boot lock command pulse |
| id_mode_i | input | 1 | Identification mode active |
| hv_override_i | input | 1 | High-voltage lock override level |
| sector_o | output | 2 | Sector of addr_i |
| erase_en_o | output | 4 | Per-sector erase enables |
| prog_allow_o | output | 1 | Program permitted, held while busy |
| busy_o | output | 1 | Internal operation in progress |
| reject_o | output | 1 | One-cycle refusal or abort pulse |
| id_data_o | output | 16 | Identification read word |

## Verification
Two pairs of functions can coincide in one cycle. The first is a lock command issued together with a boot-sector program. The bench drives both pulses in one cycle and expects the program to be accepted, with a locked status read afterwards. The second is an override release during a running override operation. The bench lowers the override mid-operation and expects busy and the enables to drop at the next edge, together with one reject pulse. Requests of several kinds issued together check that chip erase outranks sector erase, and sector erase outranks program.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [1:0] {
    SEC_BOOT = 2'd0,
    SEC_PAR1 = 2'd1,
    SEC_PAR2 = 2'd2,
    SEC_MAIN = 2'd3
  } sector_e;

  localparam int unsigned NUM_SECTORS = 4;
endpackage

// File: rtl/boot_guard_decode.sv
module boot_guard_decode
  import boot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned BOOT_LG  = 13,
  parameter int unsigned PARAM_LG = 12,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sector_e           sector_o
);
  localparam int unsigned BOOT_SZ = 1 << BOOT_LG;
  localparam int unsigned PAR_SZ  = 1 << PARAM_LG;
  localparam int unsigned MEM_SZ  = 1 << ADDR_W;

  logic [31:0] a;
  assign a = 32'(addr_i);

  generate
    if (TOP_BOOT) begin : g_top
      localparam int unsigned B_LO  = MEM_SZ - BOOT_SZ;
      localparam int unsigned P1_LO = B_LO - PAR_SZ;
      localparam int unsigned P2_LO = P1_LO - PAR_SZ;
      always_comb begin
        if (a >= B_LO)       sector_o = SEC_BOOT;
        else if (a >= P1_LO) sector_o = SEC_PAR1;
        else if (a >= P2_LO) sector_o = SEC_PAR2;
        else                 sector_o = SEC_MAIN;
      end
    end else begin : g_bottom
      localparam int unsigned P1_LO = BOOT_SZ;
      localparam int unsigned P2_LO = BOOT_SZ + PAR_SZ;
      localparam int unsigned M_LO  = BOOT_SZ + 2 * PAR_SZ;
      always_comb begin
        if (a < P1_LO)      sector_o = SEC_BOOT;
        else if (a < P2_LO) sector_o = SEC_PAR1;
        else if (a < M_LO)  sector_o = SEC_PAR2;
        else                sector_o = SEC_MAIN;
      end
    end
  endgenerate
endmodule

// File: rtl/boot_guard_id.sv
module boot_guard_id #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned BOOT_BASE = 0,
  parameter logic [15:0] MFG_CODE  = 16'h161F,
  parameter logic [15:0] DEV_CODE  = 16'h1692
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_mode_i,
  input  logic              lock_i,
  output logic [15:0]       id_data_o
);
  localparam int unsigned LOCK_ADDR = BOOT_BASE + 2;

  logic hi_zero;
  logic at_lock;
  assign hi_zero = (addr_i[ADDR_W-1:1] == '0);
  assign at_lock = (32'(addr_i) == LOCK_ADDR);

  always_comb begin
    id_data_o = '0;
    if (id_mode_i) begin
      if (hi_zero)      id_data_o = addr_i[0] ? DEV_CODE : MFG_CODE;
      else if (at_lock) id_data_o = {15'd0, lock_i};
    end
  end
endmodule

// File: rtl/boot_guard_ctrl.sv
module boot_guard_ctrl
  import boot_guard_pkg::*;
#(
  parameter int unsigned OP_CYCLES = 8,
  localparam int unsigned CNT_W    = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   por_ni,
  input  sector_e                sector_i,
  input  logic                   prog_req_i,
  input  logic                   serase_req_i,
  input  logic                   cerase_req_i,
  input  logic                   lock_req_i,
  input  logic                   hv_override_i,
  output logic                   lock_o,
  output logic [NUM_SECTORS-1:0] erase_en_o,
  output logic                   prog_allow_o,
  output logic                   busy_o,
  output logic                   reject_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  logic                   lock_q;
  logic                   busy_q, prog_q, rej_q, guard_q;
  logic [NUM_SECTORS-1:0] en_q;
  logic [CNT_W-1:0]       cnt_q;

  // request decision
  logic                   blocked, boot_hit, req_any, dec_rej, dec_prog, dec_guard;
  logic [NUM_SECTORS-1:0] dec_en;

  assign blocked  = lock_q & ~hv_override_i;
  assign boot_hit = (sector_i == SEC_BOOT);
  assign req_any  = ~busy_q & (cerase_req_i | serase_req_i | prog_req_i);

  always_comb begin
    dec_en    = '0;
    dec_prog  = 1'b0;
    dec_rej   = 1'b0;
    dec_guard = 1'b0;
    if (cerase_req_i) begin
      dec_en    = blocked ? 4'b1110 : 4'b1111;
      dec_guard = lock_q & hv_override_i;
    end else if (serase_req_i) begin
      if (boot_hit && blocked) dec_rej = 1'b1;
      else                     dec_en  = 4'(1) << sector_i;
      dec_guard = boot_hit & lock_q & hv_override_i;
    end else if (prog_req_i) begin
      if (boot_hit && blocked) dec_rej  = 1'b1;
      else                     dec_prog = 1'b1;
      dec_guard = boot_hit & lock_q & hv_override_i;
    end
  end

  // sticky lockout, cleared only by power-on init
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                  lock_q <= 1'b0;
    else if (lock_req_i && !busy_q) lock_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      prog_q  <= 1'b0;
      rej_q   <= 1'b0;
      guard_q <= 1'b0;
      en_q    <= '0;
      cnt_q   <= '0;
    end else begin
      rej_q <= 1'b0;
      if (busy_q) begin
        if ((guard_q && !hv_override_i) || cnt_q == '0) begin
          busy_q  <= 1'b0;
          prog_q  <= 1'b0;
          en_q    <= '0;
          guard_q <= 1'b0;
          rej_q   <= guard_q & ~hv_override_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (req_any) begin
        if (dec_rej) begin
          rej_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          cnt_q   <= CNT_LOAD;
          en_q    <= dec_en;
          prog_q  <= dec_prog;
          guard_q <= dec_guard;
        end
      end
    end
  end

  assign lock_o       = lock_q;
  assign erase_en_o   = en_q;
  assign prog_allow_o = prog_q;
  assign busy_o       = busy_q;
  assign reject_o     = rej_q;
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import boot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned BOOT_LG    = 13,
  parameter int unsigned PARAM_LG   = 12,
  parameter bit          TOP_BOOT   = 1'b0,
  parameter int unsigned OP_CYCLES  = 8,
  parameter logic [15:0] MFG_CODE   = 16'h161F,
  parameter logic [15:0] DEV_BOTTOM = 16'h1692,
  parameter logic [15:0] DEV_TOP    = 16'h1690
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_req_i,
  input  logic              serase_req_i,
  input  logic              cerase_req_i,
  input  logic              lock_req_i,
  input  logic              id_mode_i,
  input  logic              hv_override_i,
  output logic [1:0]        sector_o,
  output logic [3:0]        erase_en_o,
  output logic              prog_allow_o,
  output logic              busy_o,
  output logic              reject_o,
  output logic [15:0]       id_data_o
);
  localparam int unsigned BOOT_BASE = TOP_BOOT ? ((1 << ADDR_W) - (1 << BOOT_LG)) : 0;
  localparam logic [15:0] DEV_CODE  = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

  sector_e sector_w;
  logic    lock_w;

  boot_guard_decode #(
    .ADDR_W(ADDR_W), .BOOT_LG(BOOT_LG), .PARAM_LG(PARAM_LG), .TOP_BOOT(TOP_BOOT)
  ) u_decode (
    .addr_i  (addr_i),
    .sector_o(sector_w)
  );

  boot_guard_ctrl #(.OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_ni       (por_ni),
    .sector_i     (sector_w),
    .prog_req_i   (prog_req_i),
    .serase_req_i (serase_req_i),
    .cerase_req_i (cerase_req_i),
    .lock_req_i   (lock_req_i),
    .hv_override_i(hv_override_i),
    .lock_o       (lock_w),
    .erase_en_o   (erase_en_o),
    .prog_allow_o (prog_allow_o),
    .busy_o       (busy_o),
    .reject_o     (reject_o)
  );

  boot_guard_id #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)
  ) u_id (
    .addr_i   (addr_i),
    .id_mode_i(id_mode_i),
    .lock_i   (lock_w),
    .id_data_o(id_data_o)
  );

  assign sector_o = sector_w;
endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk #(
  parameter int unsigned OP_CYCLES = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       id_mode_i,
  input logic       hv_override_i,
  input logic       lock_i,
  input logic [3:0] erase_en_o,
  input logic       prog_allow_o,
  input logic       busy_o,
  input logic       reject_o,
  input logic [15:0] id_data_o
);
  logic [31:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  p_reject_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (!busy_o && erase_en_o == 4'd0 && !prog_allow_o));

  p_enables_need_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_en_o != 4'd0 || prog_allow_o) |-> busy_o);

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= OP_CYCLES);

  p_hold_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(erase_en_o) && $stable(prog_allow_o)));

  p_boot_erase_needs_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_en_o[0] && lock_i) |-> $past(hv_override_i));

  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_i |=> lock_i);

  p_id_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_i |-> (id_data_o == 16'd0));
endmodule

bind boot_guard boot_guard_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .id_mode_i    (id_mode_i),
  .hv_override_i(hv_override_i),
  .lock_i       (lock_w),
  .erase_en_o   (erase_en_o),
  .prog_allow_o (prog_allow_o),
  .busy_o       (busy_o),
  .reject_o     (reject_o),
  .id_data_o    (id_data_o)
);

// File: tb/boot_guard_bench.sv
`timescale 1ns/1ps
module boot_guard_bench;
  localparam int OPC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic [17:0] addr = '0;
  logic        prog = 0, serase = 0, cerase = 0, lockr = 0, idm = 0, hv = 0;

  logic [1:0]  sec_b, sec_t;
  logic [3:0]  en_b, en_t;
  logic        pa_b, pa_t, busy_b, busy_t, rej_b, rej_t;
  logic [15:0] id_b, id_t;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  boot_guard #(.TOP_BOOT(1'b0), .OP_CYCLES(OPC)) u_boot_guard (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr),
    .prog_req_i(prog), .serase_req_i(serase), .cerase_req_i(cerase),
    .lock_req_i(lockr), .id_mode_i(idm), .hv_override_i(hv),
    .sector_o(sec_b), .erase_en_o(en_b), .prog_allow_o(pa_b),
    .busy_o(busy_b), .reject_o(rej_b), .id_data_o(id_b));

  boot_guard #(.TOP_BOOT(1'b1), .OP_CYCLES(OPC)) u_boot_guard_top (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr),
    .prog_req_i(prog), .serase_req_i(serase), .cerase_req_i(cerase),
    .lock_req_i(lockr), .id_mode_i(idm), .hv_override_i(hv),
    .sector_o(sec_t), .erase_en_o(en_t), .prog_allow_o(pa_t),
    .busy_o(busy_t), .reject_o(rej_t), .id_data_o(id_t));

  // {addr, bottom sector, top sector}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {18'h00000, 2'd0, 2'd3}, {18'h01FFF, 2'd0, 2'd3},
    {18'h02000, 2'd1, 2'd3}, {18'h02FFF, 2'd1, 2'd3},
    {18'h03000, 2'd2, 2'd3}, {18'h03FFF, 2'd2, 2'd3},
    {18'h04000, 2'd3, 2'd3}, {18'h3BFFF, 2'd3, 2'd3},
    {18'h3C000, 2'd3, 2'd2}, {18'h3CFFF, 2'd3, 2'd2},
    {18'h3D000, 2'd3, 2'd1}, {18'h3DFFF, 2'd3, 2'd1},
    {18'h3E000, 2'd3, 2'd0}, {18'h3FFFF, 2'd3, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one-cycle request, return at the negedge after the sampling edge
  task automatic issue(input logic [17:0] a, input logic p, input logic s,
                       input logic c, input logic l);
    @(negedge clk);
    addr = a; prog = p; serase = s; cerase = c; lockr = l;
    @(negedge clk);
    prog = 0; serase = 0; cerase = 0; lockr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy_b; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic id_read(input logic [17:0] a, output logic [15:0] d);
    @(negedge clk);
    idm = 1; addr = a;
    #1 d = id_b;
    idm = 0;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1; por_ni = 1;
    @(negedge clk);
    chk("R7 reset busy", busy_b, 0);
    chk("R4 reset reject", rej_b, 0);
    chk("R5 reset enables", en_b, 0);
    chk("R11 idle id zero", id_b, 0);

    for (int i = 0; i < NV; i++) begin
      addr = VEC[i][21:4];
      #1;
      chk($sformatf("R1 decode %h", addr), sec_b, VEC[i][3:2]);
      chk($sformatf("R2 decode %h", addr), sec_t, VEC[i][1:0]);
    end

    // identification
    @(negedge clk); idm = 1; addr = 18'h0; #1;
    chk("R10 mfg", id_b, 16'h161F);
    chk("R10 mfg top", id_t, 16'h161F);
    addr = 18'h1; #1;
    chk("R10 dev bottom", id_b, 16'h1692);
    chk("R10 dev top", id_t, 16'h1690);
    addr = 18'h2; #1;
    chk("R11 bottom unlocked", id_b, 0);
    addr = 18'h3E002; #1;
    chk("R11 top unlocked", id_t, 0);
    addr = 18'h00005; #1;
    chk("R11 other addr", id_b, 0);
    idm = 0;

    // program main, length
    issue(18'h10000, 1, 0, 0, 0);
    chk("R7 prog allow", pa_b, 1);
    n = 0;
    for (int i = 0; i < 20 && busy_b; i++) begin n++; @(negedge clk); end
    chk("R7 busy length", n, OPC);
    chk("R7 prog drops", pa_b, 0);

    // sector erase parameter 1
    issue(18'h02010, 0, 1, 0, 0);
    chk("R5 sector erase p1", en_b, 4'b0010);
    wait_idle();
    // chip erase unlocked
    issue(18'h05555, 0, 0, 1, 0);
    chk("R5 chip unlocked", en_b, 4'b1111);
    wait_idle();

    // lock + boot program same cycle
    issue(18'h00010, 1, 0, 0, 1);
    chk("R12 prog accepted", pa_b, 1);
    chk("R12 no reject", rej_b, 0);
    wait_idle();
    id_read(18'h2, d);
    chk("R3 lock set", d, 1);
    @(negedge clk); idm = 1; addr = 18'h3E002; #1;
    chk("R11 top locked", id_t, 1);
    idm = 0;

    // refused boot operations
    issue(18'h00010, 1, 0, 0, 0);
    chk("R4 prog reject", rej_b, 1);
    chk("R4 no busy", busy_b, 0);
    chk("R4 no permit", pa_b, 0);
    @(negedge clk);
    chk("R4 reject one cycle", rej_b, 0);
    issue(18'h01000, 0, 1, 0, 0);
    chk("R4 serase reject", rej_b, 1);
    chk("R4 serase no en", en_b, 0);
    @(negedge clk);

    // chip erase locked
    issue(18'h05555, 0, 0, 1, 0);
    chk("R5 chip locked", en_b, 4'b1110);
    wait_idle();

    // ignored while busy
    issue(18'h20000, 1, 0, 0, 0);
    issue(18'h02000, 0, 1, 0, 0);
    chk("R8 serase ignored en", en_b, 0);
    chk("R8 prog kept", pa_b, 1);
    chk("R8 no reject", rej_b, 0);
    wait_idle();
    chk("R8 nothing queued", busy_b, 0);

    // override
    @(negedge clk); hv = 1;
    issue(18'h00100, 0, 1, 0, 0);
    chk("R6 ovr boot erase", en_b, 4'b0001);
    n = 0;
    for (int i = 0; i < 20 && busy_b; i++) begin n++; @(negedge clk); end
    chk("R6 ovr full length", n, OPC);
    issue(18'h00100, 1, 0, 0, 0);
    chk("R6 ovr prog", pa_b, 1);
    @(negedge clk); hv = 0;
    @(negedge clk);
    chk("R6 abort reject", rej_b, 1);
    chk("R6 abort busy", busy_b, 0);
    chk("R6 abort permit", pa_b, 0);
    @(negedge clk);
    issue(18'h00100, 1, 0, 0, 0);
    chk("R6 lock back", rej_b, 1);
    @(negedge clk);

    // priority
    issue(18'h00100, 1, 1, 1, 0);
    chk("R9 chip wins", en_b, 4'b1110);
    chk("R9 chip no prog", pa_b, 0);
    wait_idle();
    issue(18'h30000, 1, 1, 0, 0);
    chk("R9 sector wins", en_b, 4'b1000);
    chk("R9 sector no prog", pa_b, 0);
    wait_idle();

    // resets
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    id_read(18'h2, d);
    chk("R3 bus reset keeps lock", d, 1);
    @(negedge clk); por_ni = 0;
    @(negedge clk); por_ni = 1;
    id_read(18'h2, d);
    chk("R3 por clears lock", d, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule